// File: doc/BRIEF.md
# Serial EEPROM Address Pointer

This block keeps the current byte address of a 2048-byte serial memory. The storage is split into eight banks of 256 bytes, and into 64 pages of 32 bytes. A bus protocol engine, which is not part of this block, drives the pointer:

- When it matches a device select byte, it passes in the three bank bits from that byte.
- When it receives the word address byte, it passes in that byte.
- After each data byte, it requests one step of the pointer.

Writes step only the offset inside the current 32-byte page. Reads step through the whole address space. Between transfers the pointer holds its value, so a read that skips the word address phase goes on from where the last access stopped.

All updates are registered. The pointer changes one clock after a request and is steady in every other cycle. When a load and a step are requested in the same cycle, the load is applied and the step is dropped.

Top module: `eeprom_addr_ptr`

## Requirements
- R1: While `rst` is high at a rising clock edge, the pointer becomes 0 on that edge.
- R2: A bank load alone (`bank_ld`=1, `word_ld`=0) puts `bank_in` into address bits 10:8 and keeps bits 7:0.
- R3: A word load alone (`word_ld`=1, `bank_ld`=0) puts `word_in` into address bits 7:0 and keeps bits 10:8.
- R4: A bank load and a word load in the same cycle take both fields, giving `{bank_in, word_in}`.
- R5: A write step (`step`=1, `step_rd`=0, no load) adds one to bits 4:0 only. Offset 31 goes to 0, and bits 10:5 (the page number) do not change.
- R6: A read step (`step`=1, `step_rd`=1, no load) adds one to all 11 bits. The carry runs into the bank bits (for example 0x0FF becomes 0x100), and 0x7FF becomes 0x000.
- R7: With no load and no step, the pointer holds its value whatever `step_rd`, `bank_in` and `word_in` carry. A later read step therefore continues from the pointer left by the previous access.
- R8: If either load is requested in the same cycle as a step, only the load is applied. The step does not change any address bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bank_ld | input | 1 | Load the bank bits from a matched select byte |
| bank_in | input | 3 | Bank number taken from the select byte |
| word_ld | input | 1 | Load the low address byte |
| word_in | input | 8 | Word address byte |
| step | input | 1 | Advance the pointer after a data byte |
| step_rd | input | 1 | Step kind: 1 = read (full increment), 0 = write (page-offset increment) |
| addr | output | 11 | Current byte address |

## Verification
A load and a step can both be requested in one clock. This happens when the protocol engine reports the end of a data byte in the same cycle as a word address byte or a select byte after a repeated START.

The bench provokes this case in two ways:
- A word load together with a write step, starting from an offset where the step would otherwise change bits 4:0.
- A bank load together with a read step, starting from 0x0FF, where a step would carry into the bank bits.

The result is judged on the next cycle. The address must equal the loaded fields with every other bit unchanged. The pointer must show no trace of the increment.

// File: rtl/eeptr_pkg.sv
package eeptr_pkg;

    // Field widths of the memory address
    localparam int BANK_W = 3;                  // bank number from the select byte
    localparam int WORD_W = 8;                  // word address byte
    localparam int OFS_W  = 5;                  // byte offset inside a page
    localparam int ADDR_W = BANK_W + WORD_W;    // full byte address
    localparam int PAGE_W = ADDR_W - OFS_W;     // page number width

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [PAGE_W-1:0] page_t;

    // One operation per cycle; loads outrank steps
    typedef enum logic [1:0] {
        OP_HOLD      = 2'd0,
        OP_LOAD      = 2'd1,
        OP_STEP_PAGE = 2'd2,
        OP_STEP_FULL = 2'd3
    } ptr_op_e;

    // Which fields a load cycle replaces
    typedef struct packed {
        logic take_bank;
        logic take_word;
    } load_sel_t;

    // Write step: page number frozen, offset wraps inside the page
    function automatic addr_t step_in_page(input addr_t a);
        page_t pg;
        ofs_t  of;
        pg = a[ADDR_W-1:OFS_W];
        of = ofs_t'(a[OFS_W-1:0] + 1'b1);
        return {pg, of};
    endfunction

    // Read step: whole address wraps at the top of the memory
    function automatic addr_t step_whole(input addr_t a);
        return addr_t'(a + 1'b1);
    endfunction

endpackage

// File: rtl/eeptr_ctrl.sv
module eeptr_ctrl
    import eeptr_pkg::*;
(
    input  logic      bank_ld,
    input  logic      word_ld,
    input  logic      step,
    input  logic      step_rd,
    output ptr_op_e   op,
    output load_sel_t ld_sel
);

    always_comb begin
        ld_sel.take_bank = bank_ld;
        ld_sel.take_word = word_ld;
        if (bank_ld || word_ld) begin
            op = OP_LOAD;
        end else if (step) begin
            op = step_rd ? OP_STEP_FULL : OP_STEP_PAGE;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/eeptr_next.sv
module eeptr_next
    import eeptr_pkg::*;
(
    input  addr_t     cur,
    input  ptr_op_e   op,
    input  load_sel_t ld_sel,
    input  bank_t     bank_in,
    input  word_t     word_in,
    output addr_t     nxt
);

    addr_t loaded;
    addr_t src;

    // Per-bit field merge for a load: each bit picks new or kept value
    assign src = {bank_in, word_in};
    for (genvar b = 0; b < ADDR_W; b++) begin : g_merge
        if (b >= WORD_W) begin : g_bank
            assign loaded[b] = ld_sel.take_bank ? src[b] : cur[b];
        end else begin : g_word
            assign loaded[b] = ld_sel.take_word ? src[b] : cur[b];
        end
    end

    always_comb begin
        unique case (op)
            OP_LOAD:      nxt = loaded;
            OP_STEP_PAGE: nxt = step_in_page(cur);
            OP_STEP_FULL: nxt = step_whole(cur);
            default:      nxt = cur;
        endcase
    end

endmodule

// File: rtl/eeptr_reg.sv
module eeptr_reg
    import eeptr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  addr_t d,
    output addr_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/eeprom_addr_ptr.sv
module eeprom_addr_ptr
    import eeptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_ld,
    input  logic [BANK_W-1:0] bank_in,
    input  logic              word_ld,
    input  logic [WORD_W-1:0] word_in,
    input  logic              step,
    input  logic              step_rd,
    output logic [ADDR_W-1:0] addr
);

    ptr_op_e   op;
    load_sel_t ld_sel;
    addr_t     cur;
    addr_t     nxt;

    eeptr_ctrl i_ctrl (
        .bank_ld (bank_ld),
        .word_ld (word_ld),
        .step    (step),
        .step_rd (step_rd),
        .op      (op),
        .ld_sel  (ld_sel)
    );

    eeptr_next i_next (
        .cur     (cur),
        .op      (op),
        .ld_sel  (ld_sel),
        .bank_in (bank_in),
        .word_in (word_in),
        .nxt     (nxt)
    );

    eeptr_reg i_reg (
        .clk (clk),
        .rst (rst),
        .en  (op != OP_HOLD),
        .d   (nxt),
        .q   (cur)
    );

    assign addr = cur;

endmodule

// File: rtl/eeptr_checker.sv
module eeptr_checker
    import eeptr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bank_ld,
    input logic [BANK_W-1:0] bank_in,
    input logic              word_ld,
    input logic [WORD_W-1:0] word_in,
    input logic              step,
    input logic              step_rd,
    input logic [ADDR_W-1:0] addr
);

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> addr == '0);

    assert_bank_load_R2: assert property (@(posedge clk) disable iff (rst)
        (bank_ld && !word_ld) |=>
            (addr[ADDR_W-1:WORD_W] == $past(bank_in)) &&
            (addr[WORD_W-1:0] == $past(addr[WORD_W-1:0])));

    assert_word_load_R3: assert property (@(posedge clk) disable iff (rst)
        (word_ld && !bank_ld) |=>
            (addr[WORD_W-1:0] == $past(word_in)) &&
            $stable(addr[ADDR_W-1:WORD_W]));

    assert_both_load_R4: assert property (@(posedge clk) disable iff (rst)
        (word_ld && bank_ld) |=> addr == {$past(bank_in), $past(word_in)});

    assert_page_step_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !step_rd && !bank_ld && !word_ld) |=>
            $stable(addr[ADDR_W-1:OFS_W]) &&
            (addr[OFS_W-1:0] == OFS_W'($past(addr[OFS_W-1:0]) + 1'b1)));

    assert_full_step_R6: assert property (@(posedge clk) disable iff (rst)
        (step && step_rd && !bank_ld && !word_ld) |=>
            addr == ADDR_W'($past(addr) + 1'b1));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!step && !bank_ld && !word_ld) |=> $stable(addr));

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (step && word_ld && !bank_ld) |=>
            addr == {$past(addr[ADDR_W-1:WORD_W]), $past(word_in)});

endmodule

bind eeprom_addr_ptr eeptr_checker i_chk (
    .clk     (clk),
    .rst     (rst),
    .bank_ld (bank_ld),
    .bank_in (bank_in),
    .word_ld (word_ld),
    .word_in (word_in),
    .step    (step),
    .step_rd (step_rd),
    .addr    (addr)
);

// File: tb/test_eeprom_addr_ptr.sv
module test_eeprom_addr_ptr;

    logic        clk = 1'b0;
    logic        rst;
    logic        bank_ld;
    logic [2:0]  bank_in;
    logic        word_ld;
    logic [7:0]  word_in;
    logic        step;
    logic        step_rd;
    logic [10:0] addr;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    eeprom_addr_ptr i_eeprom_addr_ptr (
        .clk     (clk),
        .rst     (rst),
        .bank_ld (bank_ld),
        .bank_in (bank_in),
        .word_ld (word_ld),
        .word_in (word_in),
        .step    (step),
        .step_rd (step_rd),
        .addr    (addr)
    );

    task automatic check(input string req, input logic [10:0] exp);
        n_run++;
        if (addr !== exp) begin
            n_fail++;
            $display("FAIL %s: addr=0x%03h expected 0x%03h", req, addr, exp);
        end
    endtask

    // One clock: apply the request, let the edge pass, then release
    task automatic cyc(input logic bl, input logic [2:0] b, input logic wl,
                       input logic [7:0] w, input logic s, input logic sr);
        bank_ld = bl; bank_in = b; word_ld = wl; word_in = w;
        step = s; step_rd = sr;
        @(posedge clk); #1;
        bank_ld = 0; word_ld = 0; step = 0; step_rd = 0;
        bank_in = 3'h0; word_in = 8'h00;
    endtask

    task automatic set_ptr(input logic [2:0] b, input logic [7:0] w);
        cyc(1, b, 1, w, 0, 0);
    endtask

    task automatic t_reset;
        set_ptr(3'd6, 8'hA5);
        rst = 1; @(posedge clk); #1; rst = 0;
        check("R1 reset", 11'h000);
    endtask

    task automatic t_loads;
        cyc(1, 3'd5, 0, 8'hFF, 0, 0);
        check("R2 bank load", 11'h500);
        cyc(0, 3'd1, 1, 8'h3E, 0, 0);
        check("R3 word load", 11'h53E);
        cyc(1, 3'd2, 0, 8'h00, 0, 0);
        check("R2 bank load keeps low byte", 11'h23E);
        set_ptr(3'd2, 8'h1F);
        check("R4 both loads", 11'h21F);
    endtask

    task automatic t_write_steps;
        set_ptr(3'd2, 8'h1E);
        cyc(0, 0, 0, 0, 1, 0);
        check("R5 write step", 11'h21F);
        cyc(0, 0, 0, 0, 1, 0);
        check("R5 write wrap 31->0", 11'h200);
        set_ptr(3'd2, 8'h3F);
        cyc(0, 0, 0, 0, 1, 0);
        check("R5 write wrap 63->32", 11'h220);
        set_ptr(3'd7, 8'hFF);
        cyc(0, 0, 0, 0, 1, 0);
        check("R5 write wrap top page", 11'h7E0);
    endtask

    task automatic t_read_steps;
        set_ptr(3'd7, 8'hFE);
        cyc(0, 0, 0, 0, 1, 1);
        check("R6 read step", 11'h7FF);
        cyc(0, 0, 0, 0, 1, 1);
        check("R6 read wrap 2047->0", 11'h000);
        set_ptr(3'd3, 8'hFF);
        cyc(0, 0, 0, 0, 1, 1);
        check("R6 read carry into bank", 11'h400);
        set_ptr(3'd0, 8'h1F);
        cyc(0, 0, 0, 0, 1, 1);
        check("R6 read crosses page", 11'h020);
    endtask

    task automatic t_hold;
        set_ptr(3'd4, 8'h77);
        cyc(0, 3'd7, 0, 8'h11, 0, 1);
        check("R7 idle with stray inputs", 11'h477);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0);
        check("R7 hold over idle cycles", 11'h477);
        cyc(0, 0, 0, 0, 1, 1);
        check("R7 current-address read continues", 11'h478);
    endtask

    task automatic t_priority;
        set_ptr(3'd1, 8'h05);
        cyc(0, 0, 1, 8'h9C, 1, 0);
        check("R8 word load beats write step", 11'h19C);
        set_ptr(3'd0, 8'hFF);
        cyc(1, 3'd6, 0, 8'h00, 1, 1);
        check("R8 bank load beats read step", 11'h6FF);
        cyc(1, 3'd2, 1, 8'h1F, 1, 0);
        check("R8 both loads beat step", 11'h21F);
    endtask

    initial begin
        rst = 1; bank_ld = 0; bank_in = 0; word_ld = 0; word_in = 0;
        step = 0; step_rd = 0;
        repeat (2) @(posedge clk); #1;
        check("R1 reset state", 11'h000);
        rst = 0;
        t_reset();
        t_loads();
        t_write_steps();
        t_read_steps();
        t_hold();
        t_priority();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule